// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the DDR2 start-up programming sequence from hardware. It waits for the pad impedance calibration to report completion. It then works through every chip select, from chip 0 up to a maximum given at start. For each chip it issues a fixed, ordered list of direct memory commands: clock-enable NOP, precharges, the extended mode registers, the mode register with and then without DLL reset, refreshes, and the off-chip-driver calibration entry and exit. The commands go to a downstream command executor, which is not part of this block.

Each command is a 22-bit word presented on a valid/ready interface. Four programmable quiet intervals are placed inside each chip's list. A single start pulse launches the run. A one-cycle done pulse reports the end.

Top module: `ddr2i_seq`

## Requirements
- R1: During and after reset, `cmd_valid_o`, `busy_o` and `done_o` are all low.
- R2: `start_i` is only taken when the block is idle, and `busy_o` rises the cycle after. `max_chip_i` and `wait_cycles_i` are captured at that moment. A start or a change on those inputs while busy has no effect on the running sequence.
- R3: No command is presented before bit 8 of `cal_status_i` has been seen high once after start.
- R4: Command word layout: chip select in [21:20], operation code in [19:18] (0 precharge-all, 1 auto-refresh, 2 mode-register set, 3 NOP), bank in [17:16], register data in [15:0].
- R5: Each chip receives exactly 13 commands in this order: NOP, precharge-all, EMR2 (bank 2), EMR3 (bank 3), EMR (bank 1), MR, precharge-all, auto-refresh, auto-refresh, auto-refresh, MR, EMR, EMR. All words carry zero data unless R6 or R7 says otherwise.
- R6: The first MR write (bank 0) carries data 0x0742, which includes DLL reset. The second carries 0x0642, without DLL reset.
- R7: The first three extended-register writes carry data 0. The final pair (bank 1) carries 0x0384: OCD field [9:7]=7, 75-ohm termination bit 2, full drive. After that pair's first word comes 0x0004, which is OCD exit.
- R8: With N the captured wait count, `cmd_valid_o` stays low for exactly N+1 cycles at four points: after the first precharge-all is accepted, after the second auto-refresh, after the second MR, and after the OCD-default EMR.
- R9: A presented word stays valid and unchanged until it is accepted.
- R10: The 13-command list is repeated for chips 0 through the captured maximum, and never for a chip above it.
- R11: `done_o` pulses for one cycle immediately after the last chip's OCD-exit word is accepted. In that same cycle `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, taken only when idle |
| max_chip_i | input | 2 | Highest chip select to initialize |
| wait_cycles_i | input | WAIT_W | Quiet interval length N |
| cal_status_i | input | STAT_W | Pad status; bit 8 = impedance calibration done |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Executor accepts the word this cycle |
| cmd_word_o | output | 22 | Direct command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Embedded properties check several behaviours on every cycle:
- a presented word stays stable while it is stalled;
- a command never appears in the cycle straight after idle;
- the chip field never exceeds the captured maximum;
- the quiet-interval counter steps down by one;
- the done pulse is single and only comes once the block is idle.

The exact command order, the data values, the N+1 gap lengths, the repetition per chip, and the immunity to a start pulse or changed inputs in mid-run can only be shown by the bench's scenarios. The bench compares every accepted word against its own expected list, under both continuous and randomly stalled acceptance.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    localparam int CHIP_W    = 2;
    localparam int DATA_W    = 16;
    localparam int CMD_W     = CHIP_W + 2 + 2 + DATA_W;
    localparam int NUM_STEPS = 17;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);
    localparam int CAL_BIT   = 8;

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [1:0] {
        OP_PREA = 2'd0,
        OP_AREF = 2'd1,
        OP_MRS  = 2'd2,
        OP_NOP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CAL  = 2'd1,
        SQ_RUN  = 2'd2
    } sq_e;

    typedef struct packed {
        logic              is_wait;
        op_e               op;
        logic [1:0]        bank;
        logic [DATA_W-1:0] data;
    } step_t;

    localparam logic [DATA_W-1:0] MR_WITH_DLL_RST = 16'h0742;
    localparam logic [DATA_W-1:0] MR_NORMAL       = 16'h0642;
    localparam logic [2:0]        OCD_CAL_DEFAULT = 3'd7;
    localparam logic [2:0]        OCD_CAL_EXIT    = 3'd0;

    // Extended register data: OCD field at [9:7], 75-ohm termination bit 2,
    // full drive strength (bit 1 clear).
    function automatic logic [DATA_W-1:0] ext_data(input logic [2:0] ocd);
        return {6'b0, ocd, 7'b000_0100};
    endfunction

    function automatic step_t mk_step(input logic w, input op_e op,
                                      input logic [1:0] bank,
                                      input logic [DATA_W-1:0] data);
        step_t s;
        s.is_wait = w;
        s.op      = op;
        s.bank    = bank;
        s.data    = data;
        return s;
    endfunction

    function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
        case (idx)
            5'd0:    return mk_step(1'b0, OP_NOP,  2'd0, '0);
            5'd1:    return mk_step(1'b0, OP_PREA, 2'd0, '0);
            5'd2:    return mk_step(1'b1, OP_NOP,  2'd0, '0);
            5'd3:    return mk_step(1'b0, OP_MRS,  2'd2, '0);
            5'd4:    return mk_step(1'b0, OP_MRS,  2'd3, '0);
            5'd5:    return mk_step(1'b0, OP_MRS,  2'd1, '0);
            5'd6:    return mk_step(1'b0, OP_MRS,  2'd0, MR_WITH_DLL_RST);
            5'd7:    return mk_step(1'b0, OP_PREA, 2'd0, '0);
            5'd8:    return mk_step(1'b0, OP_AREF, 2'd0, '0);
            5'd9:    return mk_step(1'b0, OP_AREF, 2'd0, '0);
            5'd10:   return mk_step(1'b1, OP_NOP,  2'd0, '0);
            5'd11:   return mk_step(1'b0, OP_AREF, 2'd0, '0);
            5'd12:   return mk_step(1'b0, OP_MRS,  2'd0, MR_NORMAL);
            5'd13:   return mk_step(1'b1, OP_NOP,  2'd0, '0);
            5'd14:   return mk_step(1'b0, OP_MRS,  2'd1, ext_data(OCD_CAL_DEFAULT));
            5'd15:   return mk_step(1'b1, OP_NOP,  2'd0, '0);
            5'd16:   return mk_step(1'b0, OP_MRS,  2'd1, ext_data(OCD_CAL_EXIT));
            default: return mk_step(1'b0, OP_NOP,  2'd0, '0);
        endcase
    endfunction

    function automatic logic [CMD_W-1:0] pack_cmd(input logic [CHIP_W-1:0] chip,
                                                  input step_t s);
        return {chip, s.op, s.bank, s.data};
    endfunction

endpackage

// File: rtl/ddr2i_step_rom.sv
module ddr2i_step_rom
    import ddr2i_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output step_t             entry_o
);

    always_comb entry_o = step_lookup(step_i);

endmodule

// File: rtl/ddr2i_wait_timer.sv
module ddr2i_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);

    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

    a_r8_load_takes: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/ddr2i_seq.sv
module ddr2i_seq
    import ddr2i_pkg::*;
#(
    parameter int WAIT_W = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CHIP_W-1:0] max_chip_i,
    input  logic [WAIT_W-1:0] wait_cycles_i,
    input  logic [STAT_W-1:0] cal_status_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [CMD_W-1:0]  cmd_word_o,
    output logic              busy_o,
    output logic              done_o
);

    sq_e               state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nxt;
    logic [CHIP_W-1:0] chip_q;
    logic [CHIP_W-1:0] max_q;
    logic [WAIT_W-1:0] wait_q;
    logic              done_q;
    step_t             cur;
    step_t             nxt;
    logic              accept;
    logic              last_step;
    logic              tmr_load;
    logic              tmr_zero;
    logic              in_wait;

    assign step_nxt = step_q + STEP_W'(1);

    ddr2i_step_rom u_rom_cur (.step_i(step_q),   .entry_o(cur));
    ddr2i_step_rom u_rom_nxt (.step_i(step_nxt), .entry_o(nxt));

    ddr2i_wait_timer #(.W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (wait_q),
        .zero_o     (tmr_zero)
    );

    assign in_wait     = (state_q == SQ_RUN) && cur.is_wait;
    assign cmd_valid_o = (state_q == SQ_RUN) && !cur.is_wait;
    assign cmd_word_o  = pack_cmd(chip_q, cur);
    assign accept      = cmd_valid_o && cmd_ready_i;
    assign last_step   = (step_q == STEP_LAST);
    assign tmr_load    = accept && !last_step && nxt.is_wait;
    assign busy_o      = (state_q != SQ_IDLE);
    assign done_o      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            chip_q  <= '0;
            max_q   <= '0;
            wait_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SQ_CAL;
                        max_q   <= max_chip_i;
                        wait_q  <= wait_cycles_i;
                        chip_q  <= '0;
                        step_q  <= '0;
                    end
                end
                SQ_CAL: begin
                    if (cal_status_i[CAL_BIT]) state_q <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (cur.is_wait) begin
                        if (tmr_zero) step_q <= step_nxt;
                    end else if (accept) begin
                        if (!last_step) begin
                            step_q <= step_nxt;
                        end else if (chip_q == max_q) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            chip_q <= chip_q + CHIP_W'(1);
                            step_q <= '0;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

    a_r3_no_cmd_from_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> !cmd_valid_o);

    a_r10_chip_in_range: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_word_o[CMD_W-1 -: CHIP_W] <= max_q));

    a_r8_quiet_in_wait: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !tmr_zero) |=> !cmd_valid_o);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r11_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(accept));

endmodule

// File: tb/ddr2i_seq_bench.sv
module ddr2i_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int PER_CHIP   = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  max_chip_i = '0;
    logic [15:0] wait_cycles_i = '0;
    logic [15:0] cal_status_i = '0;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [21:0] cmd_word_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int  ready_mode = 0;
    bit  mon_en = 0;
    int  mon_total = 0;
    int  mon_n = 0;
    bit  mon_gap = 0;
    int  exp_idx = 0;
    int  low_run = 0;
    bit  pend = 0;
    logic [21:0] pend_word = '0;
    int  done_stage = 0;
    bit  seq_finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2i_seq u_ddr2i_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .max_chip_i    (max_chip_i),
        .wait_cycles_i (wait_cycles_i),
        .cal_status_i  (cal_status_i),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_ready_i   (cmd_ready_i),
        .cmd_word_o    (cmd_word_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Expected word for the k-th command of a chip, built from R4..R7.
    function automatic logic [21:0] exp_word(input int chip, input int k);
        logic [1:0]  op;
        logic [1:0]  bank;
        logic [15:0] data;
        bank = 2'd0;
        data = 16'h0;
        case (k)
            0:        op = 2'd3;
            1, 6:     op = 2'd0;
            2:        begin op = 2'd2; bank = 2'd2; end
            3:        begin op = 2'd2; bank = 2'd3; end
            4:        begin op = 2'd2; bank = 2'd1; end
            5:        begin op = 2'd2; data = 16'h0742; end
            7, 8, 9:  op = 2'd1;
            10:       begin op = 2'd2; data = 16'h0642; end
            11:       begin op = 2'd2; bank = 2'd1; data = (16'd7 << 7) | 16'h0004; end
            default:  begin op = 2'd2; bank = 2'd1; data = 16'h0004; end
        endcase
        return {chip[1:0], op, bank, data};
    endfunction

    function automatic bit wait_before(input int k);
        return (k == 2) || (k == 9) || (k == 11) || (k == 12);
    endfunction

    function automatic string word_tag(input int k, input int chip);
        if (chip > 0)                  return "R10 R4";
        if (k == 5 || k == 10)         return "R6 R4";
        if (k inside {2, 3, 4, 11, 12}) return "R7 R4";
        return "R5 R4";
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cmd_ready_i = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (mon_en) begin
            if (done_stage == 2) begin
                chk(!done_o, "R11", "done width", 32'(done_o), 32'd0);
                done_stage = 0;
                seq_finished = 1;
            end else if (done_stage == 1) begin
                chk(done_o && !busy_o, "R11", "done and idle",
                    {30'd0, done_o, busy_o}, 32'd2);
                done_stage = 2;
            end
            if (pend)
                chk(cmd_valid_o && cmd_word_o == pend_word, "R9", "held word",
                    {9'd0, cmd_valid_o, cmd_word_o}, {9'd0, 1'b1, pend_word});
            if (cmd_valid_o) begin
                if (exp_idx >= mon_total) begin
                    chk(1'b0, "R10", "extra command", 32'(cmd_word_o), 32'd0);
                end else begin
                    if (mon_gap && exp_idx > 0)
                        chk(low_run == (wait_before(exp_idx % PER_CHIP) ? mon_n + 1 : 0),
                            "R8", "quiet gap", 32'(low_run),
                            32'(wait_before(exp_idx % PER_CHIP) ? mon_n + 1 : 0));
                    low_run = 0;
                    if (cmd_ready_i) begin
                        chk(cmd_word_o == exp_word(exp_idx / PER_CHIP, exp_idx % PER_CHIP),
                            word_tag(exp_idx % PER_CHIP, exp_idx / PER_CHIP), "word",
                            32'(cmd_word_o),
                            32'(exp_word(exp_idx / PER_CHIP, exp_idx % PER_CHIP)));
                        exp_idx++;
                        if (exp_idx == mon_total) done_stage = 1;
                    end
                end
                pend = !cmd_ready_i;
                pend_word = cmd_word_o;
            end else begin
                low_run++;
                pend = 0;
            end
        end
    end

    task automatic run_seq(input int mx, input int n, input int rmode,
                           input int cal_dly, input bit poke);
        @(posedge clk);
        #1;
        max_chip_i    = mx[1:0];
        wait_cycles_i = n[15:0];
        ready_mode    = rmode;
        exp_idx       = 0;
        mon_total     = (mx + 1) * PER_CHIP;
        mon_n         = n;
        mon_gap       = (rmode == 0);
        low_run       = 0;
        pend          = 0;
        done_stage    = 0;
        seq_finished  = 0;
        cal_status_i  = 16'($urandom) & ~16'h0100;
        mon_en        = 1;
        start_i       = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(busy_o, "R2", "busy after start", 32'(busy_o), 32'd1);
        for (int i = 0; i < cal_dly; i++) begin
            @(negedge clk);
            chk(!cmd_valid_o, "R3", "no command before calibration", 32'(cmd_valid_o), 32'd0);
        end
        @(posedge clk);
        #1;
        cal_status_i = cal_status_i | 16'h0100;
        if (poke) begin
            repeat (40) @(posedge clk);
            #1;
            start_i       = 1'b1;
            max_chip_i    = 2'd0;
            wait_cycles_i = 16'd1;
            @(posedge clk);
            #1;
            start_i = 1'b0;
            @(negedge clk);
            chk(busy_o, "R2", "start while busy ignored", 32'(busy_o), 32'd1);
        end
        while (!seq_finished) @(negedge clk);
        chk(exp_idx == mon_total, "R10", "command count", 32'(exp_idx), 32'(mon_total));
        mon_en = 0;
        cal_status_i = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(!cmd_valid_o && !busy_o && !done_o, "R1", "outputs in reset",
            {29'd0, cmd_valid_o, busy_o, done_o}, 32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_valid_o && !busy_o && !done_o, "R1", "outputs after reset",
            {29'd0, cmd_valid_o, busy_o, done_o}, 32'd0);

        run_seq(0, 3, 0, 5, 1'b0);
        run_seq(3, 2 + int'($urandom % 6), 1, 3, 1'b1);
        run_seq(1, 0, 0, 0, 1'b0);
        run_seq(2, 9, 0, 2, 1'b0);
        run_seq(1, int'($urandom % 4), 1, 1, 1'b0);

        repeat (3) @(negedge clk);
        chk(!busy_o && !cmd_valid_o, "R2", "idle at end",
            {30'd0, busy_o, cmd_valid_o}, 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule